// File: doc/BRIEF.md
# Configuration-Space I/O Port Decoder

This block sits behind an I/O port access path and turns every access into a tagged physical request. Software reaches PCI configuration space through two legacy ports: a 32-bit address latch at port 0xCF8 and a four-byte data window at ports 0xCFC..0xCFF. The block keeps the 32-bit latch internally. Each access is translated combinationally, in the same cycle, into a physical address, a space tag and two memory attributes: uncacheable and strictly ordered.

A data-window access goes to configuration space only when bit 31 of the latch is set. The physical address is then built from bits 30:2 of the latch and the low two bits of the port. When bit 31 is clear, the window acts like any other I/O port. A full-width access to the latch port is tagged as an internal-register access. A write of that kind loads the latch at the next clock edge. Ports that do not fit in 16 bits are flagged as errors.

Top module: `cfgio_decoder`

## Requirements
- R1: If any `req_port` bit above bit 15 is set, `out_err` is 1, `out_space` is 0, `out_paddr` is 0 and both attributes are 0, and a write does not load the latch.
- R2: An access to port 0xCF8 with `req_size`==4 gives `out_space`==2 (internal register), `out_paddr`==`REG_PADDR` and both attributes 0. If it is a write, the latch takes `req_wdata` from the next cycle onward.
- R3: Every valid-port access to ports 0xCFC..0xCFF has `out_uncache`=1 and `out_strict`=1.
- R4: When latch bit 31 is 1, a window access gives `out_space`==1 (config) and `out_paddr` = `CFG_BASE` | (latch & 0x7FFFFFFC) | port[1:0].
- R5: When latch bit 31 is 0, a window access gives `out_space`==0 (plain I/O) and `out_paddr` = `IO_BASE` | port.
- R6: Any other port below 0x10000 gives `out_space`==0, `out_paddr` = `IO_BASE` | port, and both attributes 1.
- R7: An access to 0xCF8 whose size is not 4 is handled as plain I/O, as in R6, and a write of that kind leaves the latch unchanged.
- R8: After reset the latch is zero, so window accesses route to plain I/O.
- R9: Reads, and accesses with `req_valid` low, never change the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_port | input | PORT_IN_W | Port number as issued; upper bits must be zero |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data |
| out_paddr | output | PA_W | Translated physical address |
| out_space | output | 2 | 0 plain I/O, 1 config space, 2 internal register |
| out_uncache | output | 1 | Uncacheable attribute |
| out_strict | output | 1 | Strict-order attribute |
| out_err | output | 1 | Port number out of range |

## Verification
The assertions assume `req_size` holds 1, 2 or 4. They also assume the request inputs change only away from the rising edge, so the combinational outputs they check are settled when the clock samples them. The bench changes its inputs on the falling edge and draws every size from that set. It biases random port numbers toward the latch port, the window and the ports next to them. A share of the draws also set the upper port bits, which keeps the error path exercised without leaving the assumed input set.

// File: rtl/cfgio_decoder.sv
module cfgio_decoder #(
  parameter int PA_W = 64,
  parameter int PORT_IN_W = 32,
  parameter logic [PA_W-1:0] IO_BASE = 64'h8000_0000_0000_0000,
  parameter logic [PA_W-1:0] CFG_BASE = 64'hC000_0000_0000_0000,
  parameter logic [PA_W-1:0] REG_PADDR = 64'h0000_0000_0000_0C80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [PORT_IN_W-1:0] req_port,
  input  logic [2:0]           req_size,
  input  logic [31:0]          req_wdata,
  output logic [PA_W-1:0]      out_paddr,
  output logic [1:0]           out_space,
  output logic                 out_uncache,
  output logic                 out_strict,
  output logic                 out_err
);
  localparam logic [15:0] ADDR_PORT = 16'hCF8;
  localparam logic [13:0] WIN_LINE  = 14'h33F;
  localparam logic [1:0] SP_IO = 2'd0, SP_CFG = 2'd1, SP_REG = 2'd2;

  logic [31:0] cfg_q;

  wire        port_err = |req_port[PORT_IN_W-1:16];
  wire [15:0] port     = req_port[15:0];
  wire        hit_addr = (port == ADDR_PORT) && (req_size == 3'd4);
  wire        hit_win  = (port[15:2] == WIN_LINE);
  wire        cfg_wr   = req_valid && req_write && !port_err && hit_addr;

  wire [PA_W-1:0] io_pa  = IO_BASE | PA_W'(port);
  wire [PA_W-1:0] cfg_pa = CFG_BASE | PA_W'({1'b0, cfg_q[30:2], port[1:0]});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= req_wdata;

  always_comb begin
    out_err     = port_err;
    out_paddr   = io_pa;
    out_space   = SP_IO;
    out_uncache = 1'b1;
    out_strict  = 1'b1;
    if (port_err) begin
      out_paddr   = '0;
      out_uncache = 1'b0;
      out_strict  = 1'b0;
    end else if (hit_addr) begin
      out_paddr   = REG_PADDR;
      out_space   = SP_REG;
      out_uncache = 1'b0;
      out_strict  = 1'b0;
    end else if (hit_win && cfg_q[31]) begin
      out_paddr = cfg_pa;
      out_space = SP_CFG;
    end
  end
endmodule

module cfgio_decoder_chk #(
  parameter int PA_W = 64,
  parameter int PORT_IN_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [PORT_IN_W-1:0] req_port,
  input logic [2:0]           req_size,
  input logic [PA_W-1:0]      out_paddr,
  input logic [1:0]           out_space,
  input logic                 out_uncache,
  input logic                 out_strict,
  input logic                 out_err,
  input logic [31:0]          cfg_q
);
  wire hi_bits = |req_port[PORT_IN_W-1:16];
  wire win     = !hi_bits && (req_port[15:2] == 14'h33F);

  p_range_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hi_bits) |-> (out_err && out_space == 2'd0 && !out_uncache));

  p_latch_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hi_bits && req_port[15:0] == 16'hCF8 && req_size == 3'd4)
      |-> (out_space == 2'd2 && !out_strict));

  p_window_attr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win) |-> (out_uncache && out_strict));

  p_cfg_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && out_space == 2'd1) |-> (win && out_paddr[1:0] == req_port[1:0]));

  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && !hi_bits && req_port[15:0] == 16'hCF8 && req_size == 3'd4)
      |=> $stable(cfg_q));

  p_small_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hi_bits && req_port[15:0] == 16'hCF8 && req_size != 3'd4)
      |-> (out_space == 2'd0 && out_uncache));
endmodule

bind cfgio_decoder cfgio_decoder_chk #(.PA_W(PA_W), .PORT_IN_W(PORT_IN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_port(req_port), .req_size(req_size), .out_paddr(out_paddr),
  .out_space(out_space), .out_uncache(out_uncache), .out_strict(out_strict),
  .out_err(out_err), .cfg_q(cfg_q)
);

// File: tb/sim_cfgio_decoder.sv
`timescale 1ns/1ps
module sim_cfgio_decoder;
  localparam logic [63:0] IO_B  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] CFG_B = 64'hC000_0000_0000_0000;
  localparam logic [63:0] REG_P = 64'h0000_0000_0000_0C80;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_port = 0, req_wdata = 0;
  logic [2:0] req_size = 3'd4;
  logic [63:0] out_paddr;
  logic [1:0] out_space;
  logic out_uncache, out_strict, out_err;

  int n_run = 0, n_fail = 0;
  logic [31:0] model_cfg = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfgio_decoder u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_port(req_port), .req_size(req_size), .req_wdata(req_wdata), .out_paddr(out_paddr),
    .out_space(out_space), .out_uncache(out_uncache), .out_strict(out_strict), .out_err(out_err));

  function automatic logic [67:0] expect_of(logic [31:0] p, logic [2:0] sz, logic [31:0] cfg);
    logic [63:0] pa; logic [1:0] sp; logic unc, str, err;
    err = |p[31:16]; sp = 0; unc = 1; str = 1; pa = IO_B | {48'd0, p[15:0]};
    if (err) begin pa = 0; unc = 0; str = 0; end
    else if (p[15:0] == 16'hCF8 && sz == 3'd4) begin pa = REG_P; sp = 2; unc = 0; str = 0; end
    else if (p[15:0] >= 16'hCFC && p[15:0] <= 16'hCFF && cfg[31]) begin
      pa = CFG_B | {32'd0, cfg & 32'h7FFF_FFFC} | {62'd0, p[1:0]}; sp = 1;
    end
    return {pa, sp, unc, str};
  endfunction

  task automatic access(bit wr, logic [31:0] p, logic [2:0] sz, logic [31:0] d, string tag);
    logic [67:0] e, a;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_port = p; req_size = sz; req_wdata = d;
    #1;
    e = expect_of(p, sz, model_cfg);
    a = {out_paddr, out_space, out_uncache, out_strict};
    n_run++;
    if (a !== e || out_err !== (|p[31:16])) begin
      n_fail++;
      $display("FAIL %s port=%h size=%0d: got pa=%h sp=%0d u=%b s=%b e=%b, expected pa=%h sp=%0d u=%b s=%b e=%b",
        tag, p, sz, a[67:4], a[3:2], a[1], a[0], out_err, e[67:4], e[3:2], e[1], e[0], |p[31:16]);
    end
    if (wr && p == 32'hCF8 && sz == 3'd4) model_cfg = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1;
    access(0, 32'hCFC, 3'd4, 0, "R8 reset latch zero, window is plain I/O");
    access(0, 32'hCFE, 3'd1, 0, "R8/R5 window byte with enable clear");
    access(1, 32'hCF8, 3'd4, 32'h8000_1234, "R2 latch write tagged internal");
    access(0, 32'hCFD, 3'd1, 0, "R4 window routed to config space");
    access(0, 32'hCFC, 3'd4, 0, "R3/R4 window attributes");
    access(1, 32'hCF8, 3'd2, 32'h0, "R7 narrow latch write is plain I/O");
    access(0, 32'hCFF, 3'd1, 0, "R7 latch unchanged after narrow write");
    access(0, 32'hCF8, 3'd4, 0, "R2/R9 read of latch port");
    access(1, 32'h1_0CF8, 3'd4, 32'h0, "R1 out-of-range port");
    access(0, 32'hCFC, 3'd4, 0, "R1 latch unchanged after out-of-range write");
    access(0, 32'h0080, 3'd1, 0, "R6 ordinary port");
    access(0, 32'hCFB, 3'd1, 0, "R6 port just below window");
    access(1, 32'hCF8, 3'd4, 32'h7FFF_FFFF, "R2 write with enable clear");
    access(0, 32'hCFE, 3'd2, 0, "R5 window with enable clear");
    @(negedge clk);
    req_valid = 0; req_write = 1; req_port = 32'hCF8; req_size = 3'd4; req_wdata = 32'hFFFF_FFFF;
    access(0, 32'hCFC, 3'd4, 0, "R9 idle write cycle ignored");
    for (int i = 0; i < 600; i++) begin
      logic [31:0] p; logic [2:0] sz; int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0, 1, 2: p = 32'hCF8;
        3, 4, 5: p = 32'hCFC + $urandom_range(0, 3);
        6: p = 32'hCF4 + $urandom_range(0, 15);
        7: p = {$urandom_range(1, 255), 16'hCF8} ;
        default: p = {16'd0, 16'($urandom)};
      endcase
      case ($urandom_range(0, 2)) 0: sz = 3'd1; 1: sz = 3'd2; default: sz = 3'd4; endcase
      access($urandom_range(0, 1) == 1, p, sz, $urandom, "R1-R9 random mix");
    end
    @(negedge clk);
    finish_run();
  end
endmodule